// File: doc/BRIEF.md
# Two-Stage Watchdog Interval Timer

This block measures long intervals with two counters in cascade. A wide base counter advances once per clock while counting is enabled. A narrower main counter advances once each time the base counter wraps. When the main counter wraps, the block signals the event. In watchdog mode the signal is a one-cycle reset request. In interval mode it is an interrupt level that software clears.

Software keeps a watchdog from firing by pulsing the kick input, which clears both counters. Both counters can be read as zero-extended 32-bit words through a small registered read port. The write side of that port is accepted but never changes a counter. The default widths are 18 bits for the base counter and 12 bits for the main counter. Both widths are parameters, so a small instance can reach overflow within a short run.

Top module: `wdt_cascade_timer`

## Requirements
- R1: While `en` is 1 and `kick` is 0, the base counter increases by one on every rising clock edge.
- R2: When the base counter is all ones and counts, it returns to 0 and the main counter increases by one on that same edge. On every other edge without kick, the main counter keeps its value.
- R3: In watchdog mode (`mode` = 0), the edge on which the main counter wraps from all ones to 0 sets `rst_req` for exactly one cycle. `irq` is not affected.
- R4: In interval mode (`mode` = 1), the same overflow sets `irq`. `irq` stays 1 until a cycle with `irq_clr` = 1, which clears it on the next edge. An overflow in the same cycle as `irq_clr` leaves `irq` at 1.
- R5: After an overflow, the main counter is 0 and counting continues from there.
- R6: A cycle with `rd_en` = 1 returns `rd_valid` = 1 and the 32-bit `rd_data` on the next cycle. `rd_addr` = 0 selects the base counter and `rd_addr` = 1 selects the main counter. Bits above the counter width read 0. With `rd_en` = 0, `rd_valid` is 0 on the next cycle.
- R7: Writes (`wr_en` = 1 with any `wr_addr` and `wr_data`) leave both counter values unchanged.
- R8: After synchronous reset, both counters read 0 and `rst_req`, `irq` and `rd_valid` are 0.
- R9: A cycle with `kick` = 1 sets both counters to 0 on the next edge, even when `en` is 1.
- R10: While `en` is 0 and `kick` is 0, both counters keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the base counter counts its rising edges |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable |
| mode | input | 1 | 0 = watchdog (reset request), 1 = interval (interrupt) |
| kick | input | 1 | Clears both counters |
| irq_clr | input | 1 | Clears the interrupt level |
| rd_en | input | 1 | Read request |
| rd_addr | input | 1 | Read select: 0 base counter, 1 main counter |
| wr_en | input | 1 | Write request (ignored) |
| wr_addr | input | 1 | Write select (ignored) |
| wr_data | input | 32 | Write data (ignored) |
| rd_data | output | 32 | Zero-extended counter value |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rst_req | output | 1 | One-cycle reset request on watchdog overflow |
| irq | output | 1 | Interrupt level on interval overflow |

## Verification
The bench drives single steps, runs that stop one cycle short of a base wrap, and runs that cross the wrap by a few counts. Together these separate a missing increment, a missed carry and a carry fired one cycle early. Full-length runs to overflow in each mode show which output fires, when it fires and for how long. The interval run keeps counting past overflow to confirm the wrap to 0. It also places a clear on the overflow edge, which separates set-wins from clear-wins. Kick with enable high, a stretch with enable low, and all-ones writes to both addresses are each followed by read-back. These show that counting does not win over kick, that the counters hold, and that writes leave them untouched.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned DEF_BASE_W = 18;
    localparam int unsigned DEF_MAIN_W = 12;
    localparam int unsigned REG_W      = 32;

    typedef enum logic {
        WDT_MODE_WATCHDOG = 1'b0,
        WDT_MODE_INTERVAL = 1'b1
    } wdt_mode_e;

    typedef enum logic {
        WDT_SEL_BASE = 1'b0,
        WDT_SEL_MAIN = 1'b1
    } wdt_sel_e;

    typedef struct packed {
        logic rst_pulse;
        logic irq_level;
    } wdt_event_s;

    typedef struct packed {
        logic               valid;
        logic [REG_W-1:0]   data;
    } wdt_rd_s;

    function automatic logic is_all_ones(input logic [63:0] v, input int unsigned w);
        logic r;
        r = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i < int'(w) && !v[i]) r = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/wdt_base_counter.sv
module wdt_base_counter
    import wdt_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_BASE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             kick,
    output logic [WIDTH-1:0] cnt,
    output logic             wrap
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic at_top;

    always_comb begin
        at_top = is_all_ones(64'(cnt), WIDTH);
        wrap   = en && !kick && at_top;
    end

    always_ff @(posedge clk) begin
        if (rst || kick) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + ONE;
        end
    end

    AST_BASE_KICK: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == '0));                                        // R9
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !kick) |=> $stable(cnt));                              // R10
    AST_BASE_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));                                         // R2

endmodule

// File: rtl/wdt_main_counter.sv
module wdt_main_counter
    import wdt_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_MAIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             kick,
    output logic [WIDTH-1:0] cnt,
    output logic             ovf
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        ovf = step && !kick && is_all_ones(64'(cnt), WIDTH);
    end

    always_ff @(posedge clk) begin
        if (rst || kick) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + ONE;
        end
    end

    AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !kick) |=> $stable(cnt));                            // R2
    AST_MAIN_KICK: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == '0));                                         // R9
    AST_MAIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0));                                          // R5

endmodule

// File: rtl/wdt_event_unit.sv
module wdt_event_unit
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wdt_mode_e mode,
    input  logic      ovf,
    input  logic      irq_clr,
    output logic      rst_req,
    output logic      irq
);

    wdt_event_s state_q;
    wdt_event_s state_d;

    always_comb begin
        state_d           = state_q;
        state_d.rst_pulse = ovf && (mode == WDT_MODE_WATCHDOG);
        if (ovf && (mode == WDT_MODE_INTERVAL)) begin
            state_d.irq_level = 1'b1;
        end else if (irq_clr) begin
            state_d.irq_level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rst_req = state_q.rst_pulse;
    assign irq     = state_q.irq_level;

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);                                         // R3
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(ovf));                                // R3
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);                                    // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ovf));                                    // R4

endmodule

// File: rtl/wdt_read_port.sv
module wdt_read_port
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_W = DEF_BASE_W,
    parameter int unsigned MAIN_W = DEF_MAIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  wdt_sel_e          rd_sel,
    input  logic [BASE_W-1:0] base_cnt,
    input  logic [MAIN_W-1:0] main_cnt,
    output logic [REG_W-1:0]  rd_data,
    output logic              rd_valid
);

    logic [REG_W-1:0] base_word;
    logic [REG_W-1:0] main_word;

    generate
        if (BASE_W < REG_W) begin : g_base_pad
            assign base_word = {{(REG_W-BASE_W){1'b0}}, base_cnt};
        end else begin : g_base_full
            assign base_word = base_cnt[REG_W-1:0];
        end
        if (MAIN_W < REG_W) begin : g_main_pad
            assign main_word = {{(REG_W-MAIN_W){1'b0}}, main_cnt};
        end else begin : g_main_full
            assign main_word = main_cnt[REG_W-1:0];
        end
    endgenerate

    wdt_rd_s rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q.valid <= rd_en;
            if (rd_en) begin
                rd_q.data <= (rd_sel == WDT_SEL_MAIN) ? main_word : base_word;
            end
        end
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;

endmodule

// File: rtl/wdt_cascade_timer.sv
module wdt_cascade_timer
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_W = DEF_BASE_W,
    parameter int unsigned MAIN_W = DEF_MAIN_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        mode,
    input  logic        kick,
    input  logic        irq_clr,
    input  logic        rd_en,
    input  logic        rd_addr,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        rst_req,
    output logic        irq
);

    logic [BASE_W-1:0] base_cnt;
    logic [MAIN_W-1:0] main_cnt;
    logic              base_wrap;
    logic              main_ovf;
    wdt_mode_e         mode_e;
    wdt_sel_e          sel_e;

    // Counters are read-only: the write side is accepted and dropped.
    logic unused_wr;
    assign unused_wr = ^{wr_en, wr_addr, wr_data};

    assign mode_e = wdt_mode_e'(mode);
    assign sel_e  = wdt_sel_e'(rd_addr);

    wdt_base_counter #(.WIDTH(BASE_W)) u_base (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .kick (kick),
        .cnt  (base_cnt),
        .wrap (base_wrap)
    );

    wdt_main_counter #(.WIDTH(MAIN_W)) u_main (
        .clk  (clk),
        .rst  (rst),
        .step (base_wrap),
        .kick (kick),
        .cnt  (main_cnt),
        .ovf  (main_ovf)
    );

    wdt_event_unit u_event (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_e),
        .ovf     (main_ovf),
        .irq_clr (irq_clr),
        .rst_req (rst_req),
        .irq     (irq)
    );

    wdt_read_port #(.BASE_W(BASE_W), .MAIN_W(MAIN_W)) u_read (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_sel   (sel_e),
        .base_cnt (base_cnt),
        .main_cnt (main_cnt),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en && !kick) |=> ($stable(base_cnt) && $stable(main_cnt))); // R7
    AST_EXCLUSIVE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> !$rose(irq));                               // R3

endmodule

// File: tb/wdt_cascade_timer_tb_top.sv
`timescale 1ns/1ps
module wdt_cascade_timer_tb_top;

    localparam int unsigned BW = 4;
    localparam int unsigned MW = 3;
    localparam int unsigned BASE_LEN = 1 << BW;
    localparam int unsigned FULL_LEN = 1 << (BW + MW);

    logic        clk = 1'b0;
    logic        rst, en, mode, kick, irq_clr, rd_en, rd_addr, wr_en, wr_addr;
    logic [31:0] wr_data, rd_data;
    logic        rd_valid, rst_req, irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdt_cascade_timer #(.BASE_W(BW), .MAIN_W(MW)) dut_i (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .kick(kick),
        .irq_clr(irq_clr), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .rst_req(rst_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Read one counter with counting stopped; checks valid and data.
    task automatic rd(input logic addr, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; rd_addr = addr;
        step(1);
        chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " rd_data"}, rd_data, exp);
        rd_en = 1'b0;
        step(1);
        chk({tag, " rd_valid idle"}, 32'(rd_valid), 32'd0);
    endtask

    task automatic clear_all();
        en = 1'b0; kick = 1'b1;
        step(1);
        kick = 1'b0;
    endtask

    task automatic run(input int n);
        en = 1'b1;
        step(n);
        en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 rst_req", 32'(rst_req), 32'd0);
        chk("R8 irq", 32'(irq), 32'd0);
        chk("R8 rd_valid", 32'(rd_valid), 32'd0);
        rd(1'b0, 32'd0, "R8 base");
        rd(1'b1, 32'd0, "R8 main");
    endtask

    task automatic t_counting();
        clear_all();
        run(1);
        rd(1'b0, 32'd1, "R1 single");
        run(BASE_LEN - 2);
        rd(1'b0, 32'(BASE_LEN - 1), "R1 top");
        rd(1'b1, 32'd0, "R2 no carry early");
        run(1);
        rd(1'b0, 32'd0, "R2 base wraps");
        rd(1'b1, 32'd1, "R2 main carries");
        clear_all();
        run(2 * BASE_LEN + 7);
        rd(1'b0, 32'd7, "R6 base word");
        rd(1'b1, 32'd2, "R6 main word");
    endtask

    task automatic t_hold_and_write();
        en = 1'b0;
        step(20);
        rd(1'b0, 32'd7, "R10 base hold");
        rd(1'b1, 32'd2, "R10 main hold");
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        wr_addr = 1'b0; step(1);
        wr_addr = 1'b1; step(1);
        wr_en = 1'b0; wr_data = 32'd0;
        rd(1'b0, 32'd7, "R7 base unwritten");
        rd(1'b1, 32'd2, "R7 main unwritten");
    endtask

    task automatic t_kick();
        en = 1'b1; kick = 1'b1;
        step(1);
        kick = 1'b0; en = 1'b0;
        rd(1'b0, 32'd0, "R9 base kicked");
        rd(1'b1, 32'd0, "R9 main kicked");
    endtask

    task automatic t_watchdog();
        clear_all();
        mode = 1'b0; en = 1'b1;
        step(FULL_LEN - 1);
        chk("R3 no early pulse", 32'(rst_req), 32'd0);
        step(1);
        chk("R3 pulse", 32'(rst_req), 32'd1);
        chk("R3 irq quiet", 32'(irq), 32'd0);
        step(1);
        chk("R3 pulse ends", 32'(rst_req), 32'd0);
        en = 1'b0;
    endtask

    task automatic t_interval();
        clear_all();
        mode = 1'b1; en = 1'b1;
        step(FULL_LEN);
        chk("R4 irq set", 32'(irq), 32'd1);
        chk("R4 no rst_req", 32'(rst_req), 32'd0);
        step(9);
        en = 1'b0;
        chk("R4 irq level", 32'(irq), 32'd1);
        rd(1'b0, 32'd9, "R5 base continues");
        rd(1'b1, 32'd0, "R5 main wrapped");
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk("R4 irq cleared", 32'(irq), 32'd0);
        clear_all();
        en = 1'b1;
        step(FULL_LEN - 1);
        irq_clr = 1'b1;
        step(1);
        chk("R4 set beats clear", 32'(irq), 32'd1);
        en = 1'b0;
        step(1);
        irq_clr = 1'b0;
        chk("R4 later clear", 32'(irq), 32'd0);
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; mode = 1'b0; kick = 1'b0; irq_clr = 1'b0;
        rd_en = 1'b0; rd_addr = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        t_counting();
        t_hold_and_write();
        t_kick();
        t_watchdog();
        t_interval();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule